// File: doc/BRIEF.md
# Floating-Point Significand Rounder

This block takes a normalized floating-point value that an arithmetic datapath has produced with more precision than the storage format holds. The value arrives as a sign, a biased exponent and a significand with extra low-order bits. The block cuts the significand down to the target fraction width. It chooses the result by a 2-bit rounding-control input, and it reports whether any precision was lost.

Two of the modes are directed toward an infinity, so the sign decides whether the magnitude grows. Round-to-nearest resolves an exact halfway case toward an even last bit. An increment can carry out of the kept significand. When it does, the significand becomes 1.000…0 and the exponent is bumped by one. If the exponent is already at its largest code, it is held there and an overflow flag is raised instead.

The decision logic is combinational. The result is captured in one output register stage, which loads whenever an input is marked valid.

Top module: `fp_round_unit`

## Requirements
- R1: While `rst_n` is low, every output register is cleared to zero.
- R2: A result appears on the outputs one clock after the input is presented with `in_valid` high, and `out_valid` is high in that cycle. When `in_valid` is low, `out_valid` is low at the next clock and the other outputs keep their previous values.
- R3: The significand field is laid out as follows. Bit SIG_IN_W-1 is the integer bit. The next FRAC_W bits are the fraction. The lowest EXTRA_W bits are discarded, and the top discarded bit is the half-LSB (guard) bit. With `in_rc` = 2'b00 (nearest), the kept part is incremented in two cases: the discarded bits exceed one half, or they are exactly one half and the kept LSB is 1. A tie therefore ends on an even LSB.
- R4: With `in_rc` = 2'b01 (toward negative infinity), the kept part is incremented only when `in_sign` is 1 and a discarded bit is nonzero.
- R5: With `in_rc` = 2'b10 (toward positive infinity), the kept part is incremented only when `in_sign` is 0 and a discarded bit is nonzero.
- R6: With `in_rc` = 2'b11 (toward zero), the kept part and the exponent pass through unchanged.
- R7: In every mode, `out_inexact` is 1 exactly when at least one discarded bit is nonzero.
- R8: When the increment carries out of the kept significand, the output significand is shifted right by one, giving 1.000…0, and the exponent is incremented.
- R9: When a carry occurs and the exponent is all ones, the exponent stays all ones and `out_ovf` is 1. In every other case `out_ovf` is 0.
- R10: `out_sign` equals the input sign in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value present this cycle |
| in_rc | input | 2 | Rounding control: 00 nearest-even, 01 toward -inf, 10 toward +inf, 11 toward zero |
| in_sign | input | 1 | Sign, 1 = negative |
| in_exp | input | EXP_W | Biased exponent |
| in_sig | input | FRAC_W+1+EXTRA_W | Significand: integer bit, fraction, discarded bits |
| out_valid | output | 1 | Result present |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_sig | output | FRAC_W+1 | Rounded significand including integer bit |
| out_inexact | output | 1 | Precision was lost |
| out_ovf | output | 1 | Exponent increment saturated |

## Verification
Nearest mode is driven with discarded bits below, at and above one half, and the tie case is tried with both an odd and an even kept LSB; this separates ties-to-even from plain round-half-up. Each directed mode is applied to both signs with nonzero discarded bits, which exposes a rounder that ignores the sign or swaps the directions. All-ones kept significands with a low exponent and with an all-ones exponent isolate the carry renormalisation from the saturation path. Exact inputs and idle cycles with changed inputs show that no increment, flag or register update leaks through when none is due.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
    typedef enum logic [1:0] {
        RC_NEAR = 2'b00,
        RC_DOWN = 2'b01,
        RC_UP   = 2'b10,
        RC_CHOP = 2'b11
    } rc_e;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
#(
    parameter int EXTRA_W = 3
) (
    input  logic               sign_i,
    input  logic [1:0]         rc_i,
    input  logic               lsb_i,
    input  logic [EXTRA_W-1:0] disc_i,
    output logic               bump_o,
    output logic               inexact_o
);
    logic half;
    logic below;

    assign half = disc_i[EXTRA_W-1];

    generate
        if (EXTRA_W > 1) begin : g_below
            assign below = |disc_i[EXTRA_W-2:0];
        end else begin : g_nobelow
            assign below = 1'b0;
        end
    endgenerate

    assign inexact_o = half | below;

    always_comb begin
        unique case (rc_e'(rc_i))
            RC_NEAR: bump_o = half & (below | lsb_i);
            RC_DOWN: bump_o = sign_i & inexact_o;
            RC_UP:   bump_o = ~sign_i & inexact_o;
            RC_CHOP: bump_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int KEPT_W = 9,
    parameter int EXP_W  = 8
) (
    input  logic [KEPT_W-1:0] kept_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              bump_i,
    output logic [KEPT_W-1:0] sig_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              ovf_o
);
    logic [KEPT_W:0] sum;
    logic            carry;
    logic            exp_max;

    assign sum     = {1'b0, kept_i} + {{KEPT_W{1'b0}}, bump_i};
    assign carry   = sum[KEPT_W];
    assign exp_max = &exp_i;

    always_comb begin
        sig_o = carry ? sum[KEPT_W:1] : sum[KEPT_W-1:0];
        ovf_o = carry & exp_max;
        if (carry && !exp_max) exp_o = exp_i + {{(EXP_W-1){1'b0}}, 1'b1};
        else                   exp_o = exp_i;
    end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
    import rnd_pkg::*;
#(
    parameter int FRAC_W  = 8,
    parameter int EXP_W   = 8,
    parameter int EXTRA_W = 3,
    localparam int KEPT_W   = FRAC_W + 1,
    localparam int SIG_IN_W = KEPT_W + EXTRA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_rc,
    input  logic                in_sign,
    input  logic [EXP_W-1:0]    in_exp,
    input  logic [SIG_IN_W-1:0] in_sig,
    output logic                out_valid,
    output logic                out_sign,
    output logic [EXP_W-1:0]    out_exp,
    output logic [KEPT_W-1:0]   out_sig,
    output logic                out_inexact,
    output logic                out_ovf
);
    logic [KEPT_W-1:0]  kept;
    logic [EXTRA_W-1:0] disc;
    logic               bump;
    logic               inexact_c;
    logic [KEPT_W-1:0]  sig_c;
    logic [EXP_W-1:0]   exp_c;
    logic               ovf_c;

    assign kept = in_sig[SIG_IN_W-1:EXTRA_W];
    assign disc = in_sig[EXTRA_W-1:0];

    rnd_decide #(.EXTRA_W(EXTRA_W)) u_decide (
        .sign_i    (in_sign),
        .rc_i      (in_rc),
        .lsb_i     (kept[0]),
        .disc_i    (disc),
        .bump_o    (bump),
        .inexact_o (inexact_c)
    );

    rnd_incr #(.KEPT_W(KEPT_W), .EXP_W(EXP_W)) u_incr (
        .kept_i (kept),
        .exp_i  (in_exp),
        .bump_i (bump),
        .sig_o  (sig_c),
        .exp_o  (exp_c),
        .ovf_o  (ovf_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_sig     <= '0;
            out_inexact <= 1'b0;
            out_ovf     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign    <= in_sign;
                out_exp     <= exp_c;
                out_sig     <= sig_c;
                out_inexact <= inexact_c;
                out_ovf     <= ovf_c;
            end
        end
    end
endmodule

// File: rtl/fp_round_chk.sv
module fp_round_chk #(
    parameter int FRAC_W  = 8,
    parameter int EXP_W   = 8,
    parameter int EXTRA_W = 3,
    localparam int KEPT_W   = FRAC_W + 1,
    localparam int SIG_IN_W = KEPT_W + EXTRA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          in_rc,
    input logic                in_sign,
    input logic [EXP_W-1:0]    in_exp,
    input logic [SIG_IN_W-1:0] in_sig,
    input logic                out_valid,
    input logic                out_sign,
    input logic [EXP_W-1:0]    out_exp,
    input logic [KEPT_W-1:0]   out_sig,
    input logic                out_inexact,
    input logic                out_ovf
);
    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_sig) && $stable(out_exp)));

    p_chop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rc == 2'b11) |=>
            (out_sig == $past(in_sig[SIG_IN_W-1:EXTRA_W]) && out_exp == $past(in_exp)));

    p_exact_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sig[EXTRA_W-1:0] == '0) |=>
            (!out_inexact && out_sig == $past(in_sig[SIG_IN_W-1:EXTRA_W])));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (&out_exp));

    p_sign_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sign == $past(in_sign)));

    p_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sig[SIG_IN_W-1]) |=> out_sig[KEPT_W-1]);
endmodule

bind fp_round_unit fp_round_chk #(
    .FRAC_W (FRAC_W),
    .EXP_W  (EXP_W),
    .EXTRA_W(EXTRA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_rc      (in_rc),
    .in_sign    (in_sign),
    .in_exp     (in_exp),
    .in_sig     (in_sig),
    .out_valid  (out_valid),
    .out_sign   (out_sign),
    .out_exp    (out_exp),
    .out_sig    (out_sig),
    .out_inexact(out_inexact),
    .out_ovf    (out_ovf)
);

// File: tb/test_fp_round_unit.sv
`timescale 1ns/1ps
module test_fp_round_unit;
    localparam int FW = 8;
    localparam int EW = 8;
    localparam int XW = 3;
    localparam int KW = FW + 1;
    localparam int SW = KW + XW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_rc = 2'b00;
    logic          in_sign = 1'b0;
    logic [EW-1:0] in_exp = '0;
    logic [SW-1:0] in_sig = '0;
    logic          out_valid, out_sign, out_inexact, out_ovf;
    logic [EW-1:0] out_exp;
    logic [KW-1:0] out_sig;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    int last_sig, last_exp;
    bit last_ix, last_ov, last_sign;

    always #2 clk = ~clk;

    fp_round_unit #(.FRAC_W(FW), .EXP_W(EW), .EXTRA_W(XW)) i_fp_round_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rc(in_rc),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
        .out_sig(out_sig), .out_inexact(out_inexact), .out_ovf(out_ovf)
    );

    function automatic void model(input bit s, input int e, input int k, input int d,
                                  input int rc, output int so, output int eo,
                                  output bit ix, output bit ov);
        bit up;
        int sum;
        int half = 1 << (XW - 1);
        ix = (d != 0);
        case (rc)
            0:       up = (d > half) || (d == half && (k % 2 == 1));
            1:       up = s && ix;
            2:       up = !s && ix;
            default: up = 0;
        endcase
        sum = k + (up ? 1 : 0);
        so = sum; eo = e; ov = 0;
        if (sum >= (1 << KW)) begin
            so = sum / 2;
            if (e == (1 << EW) - 1) ov = 1;
            else eo = e + 1;
        end
    endfunction

    task automatic apply(input bit s, input int e, input int k, input int d,
                         input int rc, input string tag);
        int so, eo;
        bit ix, ov;
        model(s, e, k, d, rc, so, eo, ix, ov);
        @(negedge clk);
        in_valid = 1'b1;
        in_sign  = s;
        in_exp   = EW'(e);
        in_sig   = SW'((k << XW) | d);
        in_rc    = 2'(rc);
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b1 || out_sig !== KW'(so) || out_exp !== EW'(e == eo ? e : eo) ||
            out_inexact !== ix || out_ovf !== ov || out_sign !== s) begin
            n_fail++;
            $display("FAIL %s: got v=%b s=%b sig=%h exp=%h ix=%b ov=%b, want v=1 s=%b sig=%h exp=%h ix=%b ov=%b",
                     tag, out_valid, out_sign, out_sig, out_exp, out_inexact, out_ovf,
                     s, KW'(so), EW'(eo), ix, ov);
        end
        last_sig = so; last_exp = eo; last_ix = ix; last_ov = ov; last_sign = s;
        in_valid = 1'b0;
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        in_sign  = ~in_sign;
        in_exp   = in_exp + 8'd7;
        in_sig   = ~in_sig;
        in_rc    = in_rc + 2'd1;
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_sig !== KW'(last_sig) || out_exp !== EW'(last_exp) ||
            out_inexact !== last_ix || out_ovf !== last_ov || out_sign !== last_sign) begin
            n_fail++;
            $display("FAIL %s: got v=%b sig=%h exp=%h ix=%b ov=%b, want v=0 sig=%h exp=%h ix=%b ov=%b",
                     tag, out_valid, out_sig, out_exp, out_inexact, out_ovf,
                     KW'(last_sig), EW'(last_exp), last_ix, last_ov);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got running, want finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        in_sig   = '1;
        in_exp   = '1;
        repeat (3) @(negedge clk);
        n_run++;
        if (out_valid !== 0 || out_sig !== '0 || out_exp !== '0 || out_inexact !== 0 ||
            out_ovf !== 0 || out_sign !== 0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%b sig=%h exp=%h ix=%b ov=%b, want all zero",
                     out_valid, out_sig, out_exp, out_inexact, out_ovf);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        apply(0, 'h80, 'h12B, 5, 0, "R3 nearest above half");
        apply(0, 'h80, 'h12A, 4, 0, "R3 tie even lsb stays");
        apply(0, 'h80, 'h12B, 4, 0, "R3 tie odd lsb rounds up");
        apply(0, 'h80, 'h12B, 3, 0, "R3 below half");
        apply(1, 'h40, 'h147, 1, 1, "R4 negative toward -inf");
        apply(0, 'h40, 'h147, 6, 1, "R4 positive toward -inf");
        apply(0, 'h40, 'h147, 1, 2, "R5 positive toward +inf");
        apply(1, 'h40, 'h147, 7, 2, "R5 negative toward +inf");
        apply(1, 'h22, 'h1F3, 7, 3, "R6 truncate");
        apply(0, 'h22, 'h1F3, 0, 2, "R7 exact input");
        apply(1, 'h22, 'h1F3, 2, 3, "R7 inexact in truncate");
        apply(0, 'h10, 'h1FF, 7, 0, "R8 carry nearest");
        apply(1, 'h10, 'h1FF, 1, 1, "R8 carry toward -inf");
        apply(0, 'hFF, 'h1FF, 5, 2, "R9 saturate exponent");
        apply(1, 'h7F, 'h155, 6, 0, "R10 negative nearest");
        idle_check("R2 idle holds outputs");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule